// File: doc/BRIEF.md
# Access Permission Checker with Fault Capture

This block sits beside the address translation path and judges each access against the descriptor that covers it. A request carries the 8-bit access field of a descriptor, the current execution mode of the processor, an access-type code, the virtual address and the 14-bit maximum-offset field of the segment. From the access field the block picks the 2-bit permission level that belongs to the mode. It then decides whether that level admits the access type and whether the segment offset stays inside the segment. It also takes a fault number that the translation walker may already have raised, and it reports one verdict and one fault number for the request in the same cycle.

Requests use a valid/ready handshake. The checker is purely combinational and never applies back-pressure: `req_ready` is high in every cycle, so a request is accepted in each cycle in which `req_valid` is high. When an accepted request fails and `capture_en` is high, a fault word and the faulting virtual address are registered and stay readable until the next captured fault. The word holds the access type, the mode and the fault number. With `capture_en` low the verdict is still reported, but the registers are left untouched.

Top module: `perm_fault_logger`

## Requirements
- R1: The permission level is the 2-bit slice of `req_acc_field` that starts at bit 2*(3 - `req_mode`). Mode 3 reads bits [1:0] and mode 0 reads bits [7:6].
- R2: Permission level 0 denies every access type. The fault number is then 0x0D (access violation).
- R3: Permission level 1 admits only instruction fetch (type 4) and instruction fetch after a discontinuity (type 5). All other types are denied with fault number 0x0D.
- R4: Permission level 2 admits address fetch (type 0), operand fetch (type 1), interlocked test (type 3) and both instruction-fetch types (4, 5). It denies write (type 2) and types 6 to 15 with fault number 0x0D.
- R5: Permission level 3 admits every access type.
- R6: The segment offset is `req_vaddr[16:0]` and the segment limit is (`req_max_off` + 1) * 8 bytes. An offset equal to or above the limit gives fault number 0x0E (segment offset). Address bits above bit 16 do not affect this check.
- R7: When several faults apply at once, the reported fault number follows a fixed priority: first 0x0E, then 0x0D, then a nonzero `req_ext_fault` number from the walker (for example 0x03, 0x07 or 0x0A). `chk_ok` is 1 exactly when the reported fault number is 0.
- R8: When `req_valid`, `capture_en` and a fault all occur in one cycle, then after the next rising clock edge `flt_code` equals (type << 7) | (mode << 5) | fault number, and `flt_addr` equals the virtual address of that request.
- R9: While `capture_en` is low, or no valid request fails, `flt_code` and `flt_addr` keep their values. `chk_ok` and `chk_fault` are still reported.
- R10: Reset clears `flt_code` and `flt_addr` to zero. `req_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Always 1; the checker never stalls |
| req_acc_field | input | 8 | Descriptor access field, four 2-bit permission levels |
| req_mode | input | 2 | Current execution mode of the processor |
| req_type | input | 4 | Access-type code |
| req_vaddr | input | 32 | Virtual address of the access |
| req_max_off | input | 14 | Segment maximum-offset field |
| req_ext_fault | input | 5 | Fault number already raised by the walker, 0 if none |
| capture_en | input | 1 | Enable for updating the fault registers |
| chk_ok | output | 1 | Access admitted |
| chk_fault | output | 5 | Fault number of the request, 0 if none |
| flt_code | output | 11 | Captured fault word: type, mode, fault number |
| flt_addr | output | 32 | Captured faulting virtual address |

## Verification
Two kinds of internal error can show at the ports. A wrong permission slice or a wrong admit table changes `chk_ok` and `chk_fault` in the same cycle as the request. A wrong limit comparison also shows there, but only at the exact boundary offsets of the segment. Errors in the capture path stay hidden until the rising edge after a failing request: the next sample of `flt_code` and `flt_addr` shows either a wrong field packing or an update that should not have happened. Those registers then keep the wrong value until the next captured fault, so every later read shows it as well.

// File: rtl/apfl_pkg.sv
package apfl_pkg;
  localparam int FNUM_W  = 5;
  localparam int TYPE_W  = 4;
  localparam int MODE_W  = 2;
  localparam int FCODE_W = TYPE_W + MODE_W + FNUM_W;

  localparam logic [TYPE_W-1:0] ACC_ADDR_FETCH = 4'd0;
  localparam logic [TYPE_W-1:0] ACC_OPERAND    = 4'd1;
  localparam logic [TYPE_W-1:0] ACC_WRITE      = 4'd2;
  localparam logic [TYPE_W-1:0] ACC_INTERLOCK  = 4'd3;
  localparam logic [TYPE_W-1:0] ACC_IFETCH     = 4'd4;
  localparam logic [TYPE_W-1:0] ACC_IFETCH_JMP = 4'd5;

  localparam logic [FNUM_W-1:0] FLT_NONE    = 5'h00;
  localparam logic [FNUM_W-1:0] FLT_ACCESS  = 5'h0D;
  localparam logic [FNUM_W-1:0] FLT_SEG_OFF = 5'h0E;

  typedef enum logic [1:0] {
    PERM_DENY = 2'd0,
    PERM_EXEC = 2'd1,
    PERM_RDEX = 2'd2,
    PERM_FULL = 2'd3
  } perm_t;
endpackage

// File: rtl/apfl_perm_check.sv
module apfl_perm_check
  import apfl_pkg::*;
(
  input  logic [7:0]        acc_field,
  input  logic [MODE_W-1:0] mode,
  input  logic [TYPE_W-1:0] acc_type,
  output logic              allow
);
  perm_t perm;
  logic  is_fetch;
  logic  is_read;

  // slot index is 3 - mode, i.e. the bitwise complement of the 2-bit mode
  always_comb perm = perm_t'(acc_field[{~mode, 1'b0} +: 2]);

  always_comb begin
    is_fetch = (acc_type == ACC_IFETCH) || (acc_type == ACC_IFETCH_JMP);
    is_read  = is_fetch || (acc_type == ACC_ADDR_FETCH) ||
               (acc_type == ACC_OPERAND) || (acc_type == ACC_INTERLOCK);
  end

  always_comb begin
    unique case (perm)
      PERM_DENY: allow = 1'b0;
      PERM_EXEC: allow = is_fetch;
      PERM_RDEX: allow = is_read;
      default:   allow = 1'b1;
    endcase
  end
endmodule

// File: rtl/apfl_seg_limit.sv
module apfl_seg_limit #(
  parameter int OFF_W  = 17,
  parameter int MAXO_W = 14
) (
  input  logic [OFF_W-1:0]  offset,
  input  logic [MAXO_W-1:0] max_off,
  output logic              over
);
  localparam int LIM_W = MAXO_W + 4;

  logic [LIM_W-1:0] limit;
  logic [LIM_W-1:0] off_ext;

  always_comb begin
    limit   = ({4'b0, max_off} + LIM_W'(1)) << 3;
    off_ext = LIM_W'(offset);
    over    = off_ext >= limit;
  end
endmodule

// File: rtl/apfl_fault_regs.sv
module apfl_fault_regs
  import apfl_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap,
  input  logic [TYPE_W-1:0]  acc_type,
  input  logic [MODE_W-1:0]  mode,
  input  logic [FNUM_W-1:0]  fnum,
  input  logic [VA_W-1:0]    vaddr,
  output logic [FCODE_W-1:0] code_q,
  output logic [VA_W-1:0]    addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      addr_q <= '0;
    end else if (cap) begin
      code_q <= {acc_type, mode, fnum};
      addr_q <= vaddr;
    end
  end
endmodule

// File: rtl/perm_fault_logger.sv
module perm_fault_logger
  import apfl_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 17,
  parameter int MAXO_W = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [7:0]         req_acc_field,
  input  logic [MODE_W-1:0]  req_mode,
  input  logic [TYPE_W-1:0]  req_type,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [MAXO_W-1:0]  req_max_off,
  input  logic [FNUM_W-1:0]  req_ext_fault,
  input  logic               capture_en,
  output logic               chk_ok,
  output logic [FNUM_W-1:0]  chk_fault,
  output logic [FCODE_W-1:0] flt_code,
  output logic [VA_W-1:0]    flt_addr
);
  logic allow;
  logic over;

  apfl_perm_check u_perm (
    .acc_field (req_acc_field),
    .mode      (req_mode),
    .acc_type  (req_type),
    .allow     (allow)
  );

  apfl_seg_limit #(.OFF_W(OFF_W), .MAXO_W(MAXO_W)) u_lim (
    .offset  (req_vaddr[OFF_W-1:0]),
    .max_off (req_max_off),
    .over    (over)
  );

  always_comb begin
    if (over)              chk_fault = FLT_SEG_OFF;
    else if (!allow)       chk_fault = FLT_ACCESS;
    else                   chk_fault = req_ext_fault;
    chk_ok    = (chk_fault == FLT_NONE);
    req_ready = 1'b1;
  end

  apfl_fault_regs #(.VA_W(VA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (req_valid && capture_en && !chk_ok),
    .acc_type (req_type),
    .mode     (req_mode),
    .fnum     (chk_fault),
    .vaddr    (req_vaddr),
    .code_q   (flt_code),
    .addr_q   (flt_addr)
  );
endmodule

// File: rtl/apfl_checker.sv
module apfl_checker
  import apfl_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 17,
  parameter int MAXO_W = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [7:0]         req_acc_field,
  input logic [MODE_W-1:0]  req_mode,
  input logic [TYPE_W-1:0]  req_type,
  input logic [VA_W-1:0]    req_vaddr,
  input logic [MAXO_W-1:0]  req_max_off,
  input logic [FNUM_W-1:0]  req_ext_fault,
  input logic               capture_en,
  input logic               chk_ok,
  input logic [FNUM_W-1:0]  chk_fault,
  input logic [FCODE_W-1:0] flt_code,
  input logic [VA_W-1:0]    flt_addr
);
  logic [1:0]        lvl;
  logic [MAXO_W+3:0] lim_bytes;
  logic              beyond;
  logic              captured;

  always_comb begin
    lvl       = 2'((req_acc_field >> (6 - 2 * int'(req_mode))) & 8'h3);
    lim_bytes = (MAXO_W + 4)'((int'(req_max_off) + 1) * 8);
    beyond    = (MAXO_W + 4)'(req_vaddr[OFF_W-1:0]) >= lim_bytes;
    captured  = req_valid && capture_en && !chk_ok;
  end

  a_r2_deny_all: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == 2'd0) |-> (!chk_ok && chk_fault != 5'h00));

  a_r5_full_access: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == 2'd3 && !beyond && req_ext_fault == 5'h00) |-> chk_ok);

  a_r6_offset_fault: assert property (@(posedge clk) disable iff (!rst_n)
    beyond |-> (chk_fault == 5'h0E));

  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    captured |=> (flt_addr == $past(req_vaddr) &&
                  flt_code == {$past(req_type), $past(req_mode), $past(chk_fault)}));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !captured |=> ($stable(flt_code) && $stable(flt_addr)));
endmodule

bind perm_fault_logger apfl_checker #(.VA_W(VA_W), .OFF_W(OFF_W), .MAXO_W(MAXO_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_acc_field (req_acc_field),
  .req_mode      (req_mode),
  .req_type      (req_type),
  .req_vaddr     (req_vaddr),
  .req_max_off   (req_max_off),
  .req_ext_fault (req_ext_fault),
  .capture_en    (capture_en),
  .chk_ok        (chk_ok),
  .chk_fault     (chk_fault),
  .flt_code      (flt_code),
  .flt_addr      (flt_addr)
);

// File: tb/tb_perm_fault_logger.sv
module tb_perm_fault_logger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_acc_field = '0;
  logic [1:0]  req_mode = '0;
  logic [3:0]  req_type = '0;
  logic [31:0] req_vaddr = '0;
  logic [13:0] req_max_off = '0;
  logic [4:0]  req_ext_fault = '0;
  logic        capture_en = 1'b0;
  logic        chk_ok;
  logic [4:0]  chk_fault;
  logic [10:0] flt_code;
  logic [31:0] flt_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  perm_fault_logger dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_acc_field(req_acc_field), .req_mode(req_mode), .req_type(req_type),
    .req_vaddr(req_vaddr), .req_max_off(req_max_off), .req_ext_fault(req_ext_fault),
    .capture_en(capture_en), .chk_ok(chk_ok), .chk_fault(chk_fault),
    .flt_code(flt_code), .flt_addr(flt_addr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // drive at falling edge, settle, sample combinational outputs
  task automatic drive(input logic [7:0] acc, input logic [1:0] mode, input logic [3:0] typ,
                       input logic [31:0] va, input logic [13:0] mo, input logic [4:0] ext,
                       input logic cap);
    @(negedge clk);
    req_valid = 1'b1; req_acc_field = acc; req_mode = mode; req_type = typ;
    req_vaddr = va; req_max_off = mo; req_ext_fault = ext; capture_en = cap;
    #1;
  endtask

  task automatic verdict(input string tag, input logic [4:0] exp_fault);
    check(tag, {31'b0, chk_ok}, {31'b0, exp_fault == 5'h00});
    check(tag, {27'b0, chk_fault}, {27'b0, exp_fault});
  endtask

  task automatic t_reset;
    check("R10 reset code", {21'b0, flt_code}, 32'h0);
    check("R10 reset addr", flt_addr, 32'h0);
    check("R10 ready", {31'b0, req_ready}, 32'h1);
  endtask

  task automatic t_mode_select;
    // slots: mode0->3, mode1->2, mode2->1, mode3->0
    drive(8'b11_10_01_00, 2'd0, 4'd2, 32'h10, 14'h3FFF, 5'h0, 1'b0); verdict("R1 mode0 write", 5'h00);
    drive(8'b11_10_01_00, 2'd1, 4'd2, 32'h10, 14'h3FFF, 5'h0, 1'b0); verdict("R1 mode1 write", 5'h0D);
    drive(8'b11_10_01_00, 2'd1, 4'd1, 32'h10, 14'h3FFF, 5'h0, 1'b0); verdict("R1 mode1 read", 5'h00);
    drive(8'b11_10_01_00, 2'd2, 4'd4, 32'h10, 14'h3FFF, 5'h0, 1'b0); verdict("R1 mode2 fetch", 5'h00);
    drive(8'b11_10_01_00, 2'd2, 4'd0, 32'h10, 14'h3FFF, 5'h0, 1'b0); verdict("R1 mode2 addr", 5'h0D);
    drive(8'b11_10_01_00, 2'd3, 4'd4, 32'h10, 14'h3FFF, 5'h0, 1'b0); verdict("R1 mode3 fetch", 5'h0D);
  endtask

  task automatic t_levels;
    for (int t = 0; t < 16; t++) begin
      drive(8'h00, 2'd3, 4'(t), 32'h0, 14'h3FFF, 5'h0, 1'b0);
      verdict("R2 level0", 5'h0D);
      drive(8'h01, 2'd3, 4'(t), 32'h0, 14'h3FFF, 5'h0, 1'b0);
      verdict("R3 level1", (t == 4 || t == 5) ? 5'h00 : 5'h0D);
      drive(8'h02, 2'd3, 4'(t), 32'h0, 14'h3FFF, 5'h0, 1'b0);
      verdict("R4 level2", (t == 0 || t == 1 || t == 3 || t == 4 || t == 5) ? 5'h00 : 5'h0D);
      drive(8'h03, 2'd3, 4'(t), 32'h0, 14'h3FFF, 5'h0, 1'b0);
      verdict("R5 level3", 5'h00);
    end
  endtask

  task automatic t_limit;
    drive(8'hFF, 2'd0, 4'd1, 32'h0000_0007, 14'd0, 5'h0, 1'b0); verdict("R6 limit8 in", 5'h00);
    drive(8'hFF, 2'd0, 4'd1, 32'h0000_0008, 14'd0, 5'h0, 1'b0); verdict("R6 limit8 out", 5'h0E);
    drive(8'hFF, 2'd0, 4'd1, 32'hFFFE_001F, 14'd3, 5'h0, 1'b0); verdict("R6 limit32 in high", 5'h00);
    drive(8'hFF, 2'd0, 4'd1, 32'h0000_0020, 14'd3, 5'h0, 1'b0); verdict("R6 limit32 out", 5'h0E);
    drive(8'hFF, 2'd0, 4'd1, 32'h0001_FFFF, 14'h3FFF, 5'h0, 1'b0); verdict("R6 max seg", 5'h00);
  endtask

  task automatic t_priority;
    drive(8'h00, 2'd0, 4'd2, 32'h40, 14'd0, 5'h07, 1'b0); verdict("R7 off first", 5'h0E);
    drive(8'h00, 2'd0, 4'd2, 32'h4, 14'd0, 5'h07, 1'b0);  verdict("R7 access second", 5'h0D);
    drive(8'hFF, 2'd0, 4'd2, 32'h4, 14'd0, 5'h07, 1'b0);  verdict("R7 ext third", 5'h07);
    drive(8'hFF, 2'd0, 4'd2, 32'h4, 14'd0, 5'h0A, 1'b0);  verdict("R7 ext page", 5'h0A);
  endtask

  task automatic t_capture;
    // mode1 slot = bits[5:4]=0 -> write denied: code = (2<<7)|(1<<5)|0x0D = 0x12D
    drive(8'hCF, 2'd1, 4'd2, 32'hA5A5_0004, 14'h3FFF, 5'h0, 1'b1);
    @(negedge clk);
    check("R8 code", {21'b0, flt_code}, 32'h12D);
    check("R8 addr", flt_addr, 32'hA5A5_0004);
    // offset fault, type 5 mode 3: (5<<7)|(3<<5)|0x0E = 0x2EE
    drive(8'hFF, 2'd3, 4'd5, 32'h1234_0100, 14'd1, 5'h0, 1'b1);
    @(negedge clk);
    check("R8 code seg", {21'b0, flt_code}, 32'h2EE);
    check("R8 addr seg", flt_addr, 32'h1234_0100);
  endtask

  task automatic t_no_capture;
    drive(8'h00, 2'd0, 4'd1, 32'h0BAD_0000, 14'h3FFF, 5'h0, 1'b0);
    verdict("R9 verdict", 5'h0D);
    @(negedge clk);
    check("R9 hold code", {21'b0, flt_code}, 32'h2EE);
    check("R9 hold addr", flt_addr, 32'h1234_0100);
    // capture on but passing access: no update
    drive(8'hFF, 2'd0, 4'd1, 32'h0000_0000, 14'h3FFF, 5'h0, 1'b1);
    @(negedge clk);
    check("R9 pass hold", flt_addr, 32'h1234_0100);
    // invalid request with fault: no update
    drive(8'h00, 2'd0, 4'd1, 32'h0000_0999, 14'h3FFF, 5'h0, 1'b1);
    req_valid = 1'b0;
    @(negedge clk);
    check("R9 invalid hold", flt_addr, 32'h1234_0100);
    rst_n = 1'b0;
    #1;
    check("R10 reset clears", flt_addr, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_mode_select;
    t_levels;
    t_limit;
    t_priority;
    t_capture;
    t_no_capture;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule